// File: doc/BRIEF.md
# Cross-Clock Mailbox Register with Lane-Width Capture

This block carries one data word from a port B clock domain to a port A clock domain through a single holding register. The word does not pass through any queue storage. A qualified port B write captures the input bus into the register, keeping only the bit lanes allowed by the port B width setting, and raises a mailbox-full indication on port B at once. A four-phase level handshake brings that indication into the port A domain through two-flop synchronizers. There it shows as a port A mailbox flag.

A qualified port A read moves the stored word onto the port A output register and drops the port A flag on the same edge. The acknowledge then goes back to port B, and the port B full indication falls only when the handshake has fully returned to rest. The stored word stays in the holding register after the read. Lanes above the captured width are zero on port A.

Port B state machine: PB_EMPTY goes to PB_POSTED on a qualified write (transition WRITE). PB_POSTED goes to PB_DRAIN when the synchronized acknowledge is seen (transition ACK_SEEN). PB_DRAIN goes to PB_EMPTY when the acknowledge has dropped (transition ACK_GONE). Port A state machine: PA_IDLE goes to PA_READY when the synchronized request is seen (transition REQ_SEEN). PA_READY goes to PA_ACKED on a qualified read (transition TAKE). PA_ACKED goes to PA_IDLE when the request has dropped (transition REQ_GONE).

Top module: `mbx_cross`

## Requirements
- R1: A port B write is qualified only when `b_sel`, `b_wr`, `b_mbx` and `b_en` are all 1 at a `clk_b` rising edge. With any one of them at 0 the register is not loaded and neither flag rises.
- R2: With `b_width` = 2'b00 (long), all 36 bits of `b_din` are captured and later appear on `a_dout`.
- R3: With `b_width` = 2'b01 (word), only bits 17:0 are captured. On read, `a_dout[35:18]` is zero.
- R4: With `b_width` = 2'b10 or 2'b11 (byte), only bits 8:0 are captured. On read, `a_dout[35:9]` is zero.
- R5: `b_mbx_full` is 1 right after the `clk_b` edge of a qualified write into an empty mailbox.
- R6: `a_mbx_full` becomes 1 within 4 `clk_a` rising edges after `b_mbx_full` rises.
- R7: A port A read is qualified when `a_sel`, `a_rd`, `a_mbx` and `a_en` are all 1 at a `clk_a` edge while `a_mbx_full` is 1. After that edge `a_mbx_full` is 0 and `a_dout` holds the stored word.
- R8: `a_dout` changes only on a qualified read and holds its value otherwise.
- R9: While `b_mbx_full` is 1, further port B writes are ignored. The word read on port A is the first one written.
- R10: `b_mbx_full` stays 1 until port A has read the mailbox, and it falls within 12 `clk_b` cycles after that read.
- R11: After reset both flags are 0 and `a_dout` is zero.
- R12: A port A read while `a_mbx_full` is 0 leaves `a_dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A asynchronous reset, active low |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B asynchronous reset, active low |
| b_sel | input | 1 | Port B chip select |
| b_wr | input | 1 | Port B write direction |
| b_mbx | input | 1 | Port B mailbox select |
| b_en | input | 1 | Port B enable |
| b_width | input | 2 | Port B width: 00 long, 01 word, 10/11 byte |
| b_din | input | 36 | Port B data in |
| b_mbx_full | output | 1 | Mailbox occupied, port B view |
| a_sel | input | 1 | Port A chip select |
| a_rd | input | 1 | Port A read direction |
| a_mbx | input | 1 | Port A mailbox select |
| a_en | input | 1 | Port A enable |
| a_dout | output | 36 | Port A mailbox data out |
| a_mbx_full | output | 1 | Mailbox has a word, port A view |

## Verification
The assertions assume that both resets are asserted together and released together. They also assume that `b_width` and `b_din` are settled at the `clk_b` edge where a qualified write lands. The stimulus changes every input half a period away from the edge of its own clock, holds each write or read for one cycle, and keeps the width setting constant around each write. The two clocks run at unrelated periods, so the synchronizers see changes at shifting phases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {
        WID_LONG = 2'b00,
        WID_WORD = 2'b01,
        WID_BYTE = 2'b10,
        WID_RSVD = 2'b11
    } width_e;

    typedef enum logic [1:0] {
        PB_EMPTY  = 2'd0,
        PB_POSTED = 2'd1,
        PB_DRAIN  = 2'd2
    } pb_state_e;

    typedef enum logic [1:0] {
        PA_IDLE  = 2'd0,
        PA_READY = 2'd1,
        PA_ACKED = 2'd2
    } pa_state_e;
endpackage

// File: rtl/mbx_lane_mask.sv
module mbx_lane_mask
    import mbx_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int WORD_W = 18,
    parameter int BYTE_W = 9
) (
    input  width_e              mode,
    output logic [DATA_W-1:0]   mask
);
    logic keep_word;
    logic keep_long;

    assign keep_long = (mode == WID_LONG);
    assign keep_word = (mode == WID_WORD) || keep_long;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_lane
        if (gi < BYTE_W) begin : g_byte
            assign mask[gi] = 1'b1;
        end else if (gi < WORD_W) begin : g_word
            assign mask[gi] = keep_word;
        end else begin : g_long
            assign mask[gi] = keep_long;
        end
    end
endmodule

// File: rtl/mbx_sync2.sv
module mbx_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_port_b_fsm.sv
module mbx_port_b_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic ack_sync,
    output logic load,
    output logic req,
    output logic full
);
    pb_state_e state;
    pb_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PB_EMPTY:  if (wr_req)    state_nx = PB_POSTED;
            PB_POSTED: if (ack_sync)  state_nx = PB_DRAIN;
            PB_DRAIN:  if (!ack_sync) state_nx = PB_EMPTY;
            default:                  state_nx = PB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PB_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        load = (state == PB_EMPTY) && wr_req;
        req  = (state == PB_POSTED);
        full = (state != PB_EMPTY);
    end
endmodule

// File: rtl/mbx_port_a_fsm.sv
module mbx_port_a_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic req_sync,
    output logic take,
    output logic ack,
    output logic flag
);
    pa_state_e state;
    pa_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PA_IDLE:  if (req_sync)  state_nx = PA_READY;
            PA_READY: if (rd_req)    state_nx = PA_ACKED;
            PA_ACKED: if (!req_sync) state_nx = PA_IDLE;
            default:                 state_nx = PA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PA_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        take = (state == PA_READY) && rd_req;
        flag = (state == PA_READY);
        ack  = (state == PA_ACKED);
    end
endmodule

// File: rtl/mbx_cross.sv
module mbx_cross
    import mbx_pkg::*;
#(
    parameter int DATA_W  = 36,
    parameter int WORD_W  = 18,
    parameter int BYTE_W  = 9,
    parameter int SYNC_ST = 2
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic              b_sel,
    input  logic              b_wr,
    input  logic              b_mbx,
    input  logic              b_en,
    input  logic [1:0]        b_width,
    input  logic [DATA_W-1:0] b_din,
    output logic              b_mbx_full,
    input  logic              a_sel,
    input  logic              a_rd,
    input  logic              a_mbx,
    input  logic              a_en,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_mbx_full
);
    logic              b_wr_req;
    logic              b_load;
    logic              b_req;
    logic              b_ack_sync;
    logic [DATA_W-1:0] b_mask;
    logic [DATA_W-1:0] mbx_q;
    logic              a_rd_req;
    logic              a_take;
    logic              a_ack;
    logic              a_req_sync;
    width_e            b_mode;

    assign b_mode   = width_e'(b_width);
    assign b_wr_req = b_sel && b_wr && b_mbx && b_en;
    assign a_rd_req = a_sel && a_rd && a_mbx && a_en;

    mbx_lane_mask #(
        .DATA_W (DATA_W),
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_mask (
        .mode (b_mode),
        .mask (b_mask)
    );

    mbx_port_b_fsm u_pb (
        .clk      (clk_b),
        .rst_n    (rst_b_n),
        .wr_req   (b_wr_req),
        .ack_sync (b_ack_sync),
        .load     (b_load),
        .req      (b_req),
        .full     (b_mbx_full)
    );

    mbx_port_a_fsm u_pa (
        .clk      (clk_a),
        .rst_n    (rst_a_n),
        .rd_req   (a_rd_req),
        .req_sync (a_req_sync),
        .take     (a_take),
        .ack      (a_ack),
        .flag     (a_mbx_full)
    );

    mbx_sync2 #(.STAGES(SYNC_ST)) u_req_sync (
        .clk   (clk_a),
        .rst_n (rst_a_n),
        .d     (b_req),
        .q     (a_req_sync)
    );

    mbx_sync2 #(.STAGES(SYNC_ST)) u_ack_sync (
        .clk   (clk_b),
        .rst_n (rst_b_n),
        .d     (a_ack),
        .q     (b_ack_sync)
    );

    // Holding register, port B domain; frozen while the handshake is busy.
    always_ff @(posedge clk_b or negedge rst_b_n) begin
        if (!rst_b_n) begin
            mbx_q <= '0;
        end else if (b_load) begin
            mbx_q <= b_din & b_mask;
        end
    end

    // Output register, port A domain; mbx_q is stable whenever a_take is high.
    always_ff @(posedge clk_a or negedge rst_a_n) begin
        if (!rst_a_n) begin
            a_dout <= '0;
        end else if (a_take) begin
            a_dout <= mbx_q;
        end
    end
endmodule

// File: rtl/mbx_cross_chk.sv
module mbx_cross_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk_a,
    input logic              rst_a_n,
    input logic              clk_b,
    input logic              rst_b_n,
    input logic              b_sel,
    input logic              b_wr,
    input logic              b_mbx,
    input logic              b_en,
    input logic              b_mbx_full,
    input logic              a_sel,
    input logic              a_rd,
    input logic              a_mbx,
    input logic              a_en,
    input logic              a_mbx_full,
    input logic [DATA_W-1:0] a_dout,
    input logic [DATA_W-1:0] mbx_q
);
    logic wr_ok;
    logic rd_ok;

    assign wr_ok = b_sel && b_wr && b_mbx && b_en;
    assign rd_ok = a_sel && a_rd && a_mbx && a_en;

    AST_WR_SETS_FULL: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (wr_ok && !b_mbx_full) |=> b_mbx_full) else $error("write did not set full"); // R5

    AST_FULL_FREEZES_WORD: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        b_mbx_full |=> $stable(mbx_q)) else $error("word changed while full"); // R9

    AST_NO_LOAD_UNQUALIFIED: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!wr_ok && !b_mbx_full) |=> !b_mbx_full) else $error("full without write"); // R1

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (rd_ok && a_mbx_full) |=> !a_mbx_full) else $error("read left flag set"); // R7

    AST_DOUT_HOLDS: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        !(rd_ok && a_mbx_full) |=> $stable(a_dout)) else $error("dout moved"); // R8
endmodule

bind mbx_cross mbx_cross_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_a      (clk_a),
    .rst_a_n    (rst_a_n),
    .clk_b      (clk_b),
    .rst_b_n    (rst_b_n),
    .b_sel      (b_sel),
    .b_wr       (b_wr),
    .b_mbx      (b_mbx),
    .b_en       (b_en),
    .b_mbx_full (b_mbx_full),
    .a_sel      (a_sel),
    .a_rd       (a_rd),
    .a_mbx      (a_mbx),
    .a_en       (a_en),
    .a_mbx_full (a_mbx_full),
    .a_dout     (a_dout),
    .mbx_q      (mbx_q)
);

// File: tb/mbx_cross_bench.sv
module mbx_cross_bench;
    logic        clk_a = 1'b0;
    logic        clk_b = 1'b0;
    logic        rst_a_n = 1'b0;
    logic        rst_b_n = 1'b0;
    logic        b_sel = 1'b0, b_wr = 1'b0, b_mbx = 1'b0, b_en = 1'b0;
    logic [1:0]  b_width = 2'b00;
    logic [35:0] b_din = '0;
    logic        b_mbx_full;
    logic        a_sel = 1'b0, a_rd = 1'b0, a_mbx = 1'b0, a_en = 1'b0;
    logic [35:0] a_dout;
    logic        a_mbx_full;

    int compared = 0;
    int mismatched = 0;
    logic [35:0] exp_dout = '0;   // model of port A output
    logic [35:0] mdl_word = '0;   // model of word held in mailbox
    bit          mdl_full = 0;    // model: mailbox occupied
    bit          mon_on = 0;

    always #4 clk_a = ~clk_a;     // 125 MHz
    always #7 clk_b = ~clk_b;

    mbx_cross u_mbx_cross (
        .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
        .b_sel(b_sel), .b_wr(b_wr), .b_mbx(b_mbx), .b_en(b_en),
        .b_width(b_width), .b_din(b_din), .b_mbx_full(b_mbx_full),
        .a_sel(a_sel), .a_rd(a_rd), .a_mbx(a_mbx), .a_en(a_en),
        .a_dout(a_dout), .a_mbx_full(a_mbx_full)
    );

    function automatic logic [35:0] lanes(input logic [1:0] w);
        case (w)
            2'b00:   return {36{1'b1}};
            2'b01:   return {18'd0, {18{1'b1}}};
            default: return {27'd0, {9{1'b1}}};
        endcase
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the output register (R8, R12)
    always @(negedge clk_a) begin
        if (mon_on) check("R8", a_dout, exp_dout);
    end

    task automatic b_write(input logic [35:0] d, input logic [1:0] w,
                           input logic [3:0] ctl);
        @(negedge clk_b);
        {b_sel, b_wr, b_mbx, b_en} = ctl;
        b_width = w;
        b_din = d;
        @(posedge clk_b);
        if (ctl == 4'hF && !mdl_full) begin
            mdl_word = d & lanes(w);
            mdl_full = 1;
        end
        @(negedge clk_b);
        {b_sel, b_wr, b_mbx, b_en} = 4'h0;
        b_din = '0;
        check("R5", {35'd0, b_mbx_full}, {35'd0, mdl_full});
    endtask

    task automatic wait_a_flag();
        int n = 0;
        for (int i = 0; i < 8; i++) begin
            if (a_mbx_full) break;
            @(posedge clk_a);
            #1;
            n++;
        end
        compared++;
        if (!a_mbx_full || n > 4) begin
            mismatched++;
            $display("FAIL R6: actual flag %0d after %0d edges expected 1 within 4", a_mbx_full, n);
        end
    endtask

    task automatic a_read(input logic [3:0] ctl);
        bit was_set;
        @(negedge clk_a);
        {a_sel, a_rd, a_mbx, a_en} = ctl;
        was_set = a_mbx_full;
        @(posedge clk_a);
        #1;
        if (was_set && ctl == 4'hF) exp_dout = mdl_word;
        @(negedge clk_a);
        {a_sel, a_rd, a_mbx, a_en} = 4'h0;
        if (was_set && ctl == 4'hF)
            check("R7", {35'd0, a_mbx_full}, 36'd0);
    endtask

    task automatic wait_b_clear();
        int n = 0;
        for (int i = 0; i < 20; i++) begin
            if (!b_mbx_full) break;
            @(posedge clk_b);
            #1;
            n++;
        end
        mdl_full = 0;
        compared++;
        if (b_mbx_full || n > 12) begin
            mismatched++;
            $display("FAIL R10: actual full %0d after %0d cycles expected 0 within 12", b_mbx_full, n);
        end
    endtask

    task automatic full_round(input logic [35:0] d, input logic [1:0] w, input string req);
        b_write(d, w, 4'hF);
        wait_a_flag();
        a_read(4'hF);
        check(req, a_dout, d & lanes(w));
        wait_b_clear();
    endtask

    initial begin
        #(200000 * 8);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #30;
        rst_a_n = 1'b1;
        rst_b_n = 1'b1;
        @(negedge clk_a);
        check("R11", {34'd0, a_mbx_full, b_mbx_full}, 36'd0);
        check("R11", a_dout, 36'd0);
        mon_on = 1;

        // R1: each missing qualifier blocks the write
        b_write(36'h123456789, 2'b00, 4'b1110);
        b_write(36'h123456789, 2'b00, 4'b1101);
        b_write(36'h123456789, 2'b00, 4'b1011);
        b_write(36'h123456789, 2'b00, 4'b0111);
        repeat (8) @(negedge clk_a);
        check("R1", {34'd0, a_mbx_full, b_mbx_full}, 36'd0);

        // R12: read with empty mailbox leaves output alone
        a_read(4'hF);
        check("R12", a_dout, 36'd0);

        full_round(36'hABCDE1234, 2'b00, "R2");
        full_round(36'hFFFFFFFFF, 2'b01, "R3");
        full_round(36'hFFFFFFFFF, 2'b10, "R4");
        full_round(36'h5A5A5A5A5, 2'b11, "R4");

        // R9 and R10: second write while full is dropped; full holds until read
        b_write(36'h0CAFEF00D, 2'b00, 4'hF);
        wait_a_flag();
        b_write(36'h111111111, 2'b00, 4'hF);
        repeat (10) @(negedge clk_b);
        check("R10", {35'd0, b_mbx_full}, 36'd1);
        a_read(4'b1011);                         // unqualified read: R7
        check("R7", {35'd0, a_mbx_full}, 36'd1);
        a_read(4'hF);
        check("R9", a_dout, 36'h0CAFEF00D);
        wait_b_clear();

        // R8: output holds after the read, mailbox word reused
        repeat (6) @(negedge clk_a);
        check("R8", a_dout, 36'h0CAFEF00D);
        full_round(36'h876543210, 2'b01, "R3");

        mon_on = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule